// File: doc/BRIEF.md
# Memory Fence Ordering Gate

This block sits beside the load/store issue stage of one hardware thread and enforces memory ordering around fence instructions. It tracks how many accesses of each of four kinds are in flight (memory read, memory write, device input, device output). Each kind has its own counter. A counter rises when an access of that kind is granted and issued, and falls when that access's response comes back.

A fence instruction carries two 4-bit kind sets. The first set lists the kinds that must finish. The second set lists the kinds that must wait. While a fence is held, later accesses of a waiting kind are refused a grant until every counter named in the first set reaches zero. Kinds outside the waiting set keep flowing.

An instruction-stream fence waits only for outstanding memory writes. It then raises a one-cycle flush toward the instruction-fetch path and retires. Only one fence is held at a time, and a fence offered while another is held is refused.

Top module: `fence_gate`

## Requirements
- R1: After reset no fence is held: `fence_ready` is 1, `fetch_flush` is 0 and all four `acc_gnt` bits are 1.
- R2: A word on `fence_instr` with `fence_valid` high is taken as a fence only if bits [6:0] equal 0001111 and bits [14:12] equal 000 (ordering fence) or 001 (instruction-stream fence). Any other word is ignored, and no grant changes as a result.
- R3: Port bit index maps to kind: 0 = memory write, 1 = memory read, 2 = device output, 3 = device input. This holds for `acc_req`, `acc_gnt` and `rsp_valid`. An ordering fence takes its must-finish set from instruction bits [27:24] and its must-wait set from bits [23:20], using the same bit order.
- R4: From the cycle after an ordering fence is accepted, `acc_gnt` is 0 for every kind in its must-wait set while the fence is held.
- R5: While a fence is held, `acc_gnt` stays 1 for every kind outside its must-wait set, as long as that kind's counter is not full.
- R6: The fence is satisfied in the first cycle, counted from the cycle after acceptance, in which every counter of its must-finish set reads zero. It is released in the next cycle, and the blocked grants return then.
- R7: `fence_ready` is 0 while a fence is held. A fence offered in that time is not taken and has no effect.
- R8: An instruction-stream fence blocks no access kind. It is satisfied when the memory-write counter reads zero. `fetch_flush` is 1 for exactly one cycle, the cycle in which the fence is released.
- R9: Each counter is CNT_W bits wide and counts granted requests up and responses down. At its maximum (15 with the default width), the grant for that kind is 0 until a response arrives.
- R10: A granted request and a response of the same kind in the same cycle leave that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 4 | Per-kind access request; issued when the matching grant is 1 |
| acc_gnt | output | 4 | Per-kind issue permission |
| rsp_valid | input | 4 | Per-kind completion of one outstanding access |
| fence_valid | input | 1 | A candidate fence word is offered |
| fence_instr | input | 32 | Instruction word of the candidate fence |
| fence_ready | output | 1 | No fence held; an offered fence is taken |
| fetch_flush | output | 1 | One-cycle flush request to instruction fetch |

## Verification
The assertions take for granted that the memory side never returns a response for a kind that has nothing outstanding. Without that rule a counter would wrap below zero, and the step-by-one counter check would not hold. The stimulus keeps to this rule by issuing a response only after it has issued the matching request and seen its grant. It also drains every counter at the end of each scenario. Fences are offered either while none is held or deliberately during a held fence, so that refusal can be observed.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;
    localparam int NKIND = 4;

    typedef enum logic [1:0] {
        K_WR  = 2'd0,
        K_RD  = 2'd1,
        K_OUT = 2'd2,
        K_IN  = 2'd3
    } kind_e;

    localparam logic [6:0] OPC_ORDER   = 7'b0001111;
    localparam logic [2:0] SUB_ORDER   = 3'b000;
    localparam logic [2:0] SUB_ISTREAM = 3'b001;

    typedef struct packed {
        logic             held;
        logic             istream;
        logic [NKIND-1:0] finish_set;
        logic [NKIND-1:0] wait_set;
        logic             flush;
    } gate_st_t;
endpackage

// File: rtl/fence_word_decode.sv
module fence_word_decode
    import fence_gate_pkg::*;
(
    input  logic [6:0]       opcode,
    input  logic [2:0]       subop,
    input  logic [7:0]       set_bits,
    output logic             is_order,
    output logic             is_istream,
    output logic [NKIND-1:0] finish_set,
    output logic [NKIND-1:0] wait_set
);
    always_comb begin
        is_order   = (opcode == OPC_ORDER) && (subop == SUB_ORDER);
        is_istream = (opcode == OPC_ORDER) && (subop == SUB_ISTREAM);
        finish_set = set_bits[7:4];
        wait_set   = set_bits[3:0];
    end
endmodule

// File: rtl/kind_counter.sv
module kind_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt   = cnt_q;
    assign full  = (cnt_q == CNT_MAX);
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/fence_gate.sv
module fence_gate
    import fence_gate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  acc_req,
    output logic [3:0]  acc_gnt,
    input  logic [3:0]  rsp_valid,
    input  logic        fence_valid,
    input  logic [31:0] fence_instr,
    output logic        fence_ready,
    output logic        fetch_flush
);
    logic [NKIND-1:0][CNT_W-1:0] cnt_q;
    logic [NKIND-1:0]            kind_full;
    logic [NKIND-1:0]            kind_empty;
    logic [NKIND-1:0]            issue;

    logic             dec_order;
    logic             dec_istream;
    logic [NKIND-1:0] dec_finish;
    logic [NKIND-1:0] dec_wait;
    logic             unused_fields;

    gate_st_t st_d, st_q;
    logic     take;
    logic     drained;

    assign unused_fields = ^{fence_instr[31:28], fence_instr[19:15], fence_instr[11:7]};

    fence_word_decode u_dec (
        .opcode     (fence_instr[6:0]),
        .subop      (fence_instr[14:12]),
        .set_bits   (fence_instr[27:20]),
        .is_order   (dec_order),
        .is_istream (dec_istream),
        .finish_set (dec_finish),
        .wait_set   (dec_wait)
    );

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        assign acc_gnt[k] = !kind_full[k] && !(st_q.held && st_q.wait_set[k]);
        assign issue[k]   = acc_req[k] && acc_gnt[k];

        kind_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (issue[k]),
            .dec   (rsp_valid[k]),
            .cnt   (cnt_q[k]),
            .full  (kind_full[k]),
            .empty (kind_empty[k])
        );
    end

    assign fence_ready = !st_q.held;
    assign take        = fence_valid && fence_ready && (dec_order || dec_istream);
    assign drained     = &(kind_empty | ~st_q.finish_set);

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (st_q.held) begin
            if (drained) begin
                st_d.held  = 1'b0;
                st_d.flush = st_q.istream;
            end
        end else if (take) begin
            st_d.held    = 1'b1;
            st_d.istream = dec_istream;
            if (dec_istream) begin
                st_d.finish_set = NKIND'(1) << K_WR;
                st_d.wait_set   = '0;
            end else begin
                st_d.finish_set = dec_finish;
                st_d.wait_set   = dec_wait;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_flush = st_q.flush;
endmodule

// File: rtl/fence_gate_chk.sv
module fence_gate_chk #(
    parameter int CNT_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [3:0]            acc_req,
    input logic [3:0]            acc_gnt,
    input logic [3:0]            rsp_valid,
    input logic                  fence_valid,
    input logic [31:0]           fence_instr,
    input logic                  fence_ready,
    input logic                  fetch_flush,
    input logic [3:0][CNT_W-1:0] cnt_q
);
    logic opc_hit;
    logic take_order;
    logic take_any;

    assign opc_hit    = fence_valid && fence_ready && (fence_instr[6:0] == 7'b0001111);
    assign take_order = opc_hit && (fence_instr[14:12] == 3'b000);
    assign take_any   = opc_hit && (fence_instr[14:12] == 3'b000 || fence_instr[14:12] == 3'b001);

    // R7
    single_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_any |=> !fence_ready);

    // R4
    wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_order |=> ((acc_gnt & $past(fence_instr[23:20])) == 4'b0000));

    // R8
    flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_flush |=> !fetch_flush);

    // R8
    flush_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_flush) |-> $past(!fence_ready));

    for (genvar k = 0; k < 4; k++) begin : g_k
        // R9
        rsp_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[k] |-> (cnt_q[k] != '0));

        // R10
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, cnt_q[k]} == {1'b0, $past(cnt_q[k])}) ||
            ({1'b0, cnt_q[k]} == {1'b0, $past(cnt_q[k])} + (CNT_W+1)'(1)) ||
            ({1'b0, cnt_q[k]} + (CNT_W+1)'(1) == {1'b0, $past(cnt_q[k])}));
    end

    logic unused_req;
    assign unused_req = ^acc_req;
endmodule

bind fence_gate fence_gate_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fence_gate.sv
module tb_fence_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  acc_req = '0;
    logic [3:0]  acc_gnt;
    logic [3:0]  rsp_valid = '0;
    logic        fence_valid = 1'b0;
    logic [31:0] fence_instr = '0;
    logic        fence_ready;
    logic        fetch_flush;

    int total = 0;
    int failed = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [3:0] gnt;
        logic       rdy;
        logic       fl;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fence_gate dut (
        .clk, .rst_n, .acc_req, .acc_gnt, .rsp_valid,
        .fence_valid, .fence_instr, .fence_ready, .fetch_flush
    );

    function automatic logic [31:0] order_word(input logic [3:0] fin, input logic [3:0] wt);
        return {4'b0000, fin, wt, 5'd0, 3'b000, 5'd0, 7'b0001111};
    endfunction

    function automatic logic [31:0] istream_word();
        return {17'd0, 3'b001, 5'd0, 7'b0001111};
    endfunction

    task automatic step(input string tag, input logic [3:0] req, input logic [3:0] rsp,
                        input logic fv, input logic [31:0] ins,
                        input logic [3:0] eg, input logic er, input logic ef);
        exp_t e;
        @(negedge clk);
        acc_req     = req;
        rsp_valid   = rsp;
        fence_valid = fv;
        fence_instr = ins;
        e.tag = tag; e.gnt = eg; e.rdy = er; e.fl = ef;
        sb.push_back(e);
    endtask

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "acc_gnt", acc_gnt, e.gnt);
                chk(e.tag, "fence_ready", {3'b0, fence_ready}, {3'b0, e.rdy});
                chk(e.tag, "fetch_flush", {3'b0, fetch_flush}, {3'b0, e.fl});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        total++;
        failed++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step("R1", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // Ordering fence: finish {R,W}, wait {W}; one write outstanding
        step("R9", 4'b0001, 4'b0000, 0, '0, 4'b1111, 1, 0);
        step("R3", 4'b0000, 4'b0000, 1, order_word(4'b0011, 4'b0001), 4'b1111, 1, 0);
        // R4 write blocked, R5 others open, R7 second fence refused
        step("R4", 4'b0000, 4'b0000, 1, order_word(4'b0000, 4'b0010), 4'b1110, 0, 0);
        step("R7", 4'b0000, 4'b0001, 0, '0, 4'b1110, 0, 0);
        step("R6", 4'b0000, 4'b0000, 0, '0, 4'b1110, 0, 0);
        step("R6", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);
        step("R7", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // R6 nothing outstanding: held exactly one cycle, all kinds waiting
        step("R6", 4'b0000, 4'b0000, 1, order_word(4'b1111, 4'b1111), 4'b1111, 1, 0);
        step("R4", 4'b0000, 4'b0000, 0, '0, 4'b0000, 0, 0);
        step("R6", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // R5 wait set {I,O}; memory kinds stay open
        step("R5", 4'b0000, 4'b0000, 1, order_word(4'b0000, 4'b1100), 4'b1111, 1, 0);
        step("R5", 4'b0000, 4'b0000, 0, '0, 4'b0011, 0, 0);
        step("R5", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // R8 instruction-stream fence with a write outstanding
        step("R8", 4'b0001, 4'b0000, 0, '0, 4'b1111, 1, 0);
        step("R8", 4'b0000, 4'b0000, 1, istream_word(), 4'b1111, 1, 0);
        step("R8", 4'b0000, 4'b0000, 0, '0, 4'b1111, 0, 0);
        step("R8", 4'b0000, 4'b0001, 0, '0, 4'b1111, 0, 0);
        step("R8", 4'b0000, 4'b0000, 0, '0, 4'b1111, 0, 0);
        step("R8", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 1);
        step("R8", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // R2 ignored words: wrong opcode, wrong sub-op
        step("R2", 4'b0000, 4'b0000, 1, {4'b0, 4'b1111, 4'b1111, 5'd0, 3'b000, 5'd0, 7'b0010011}, 4'b1111, 1, 0);
        step("R2", 4'b0000, 4'b0000, 1, {4'b0, 4'b1111, 4'b1111, 5'd0, 3'b010, 5'd0, 7'b0001111}, 4'b1111, 1, 0);
        step("R2", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        // R9 fill the device-input counter to its maximum
        for (int i = 0; i < 15; i++) begin
            step("R9", 4'b1000, 4'b0000, 0, '0, 4'b1111, 1, 0);
        end
        step("R9", 4'b1000, 4'b0000, 0, '0, 4'b0111, 1, 0);
        step("R9", 4'b0000, 4'b1000, 0, '0, 4'b0111, 1, 0);
        // R10 request and response together keep the count at 14
        step("R10", 4'b1000, 4'b1000, 0, '0, 4'b1111, 1, 0);
        step("R10", 4'b1000, 4'b0000, 0, '0, 4'b1111, 1, 0);
        step("R10", 4'b0000, 4'b0000, 0, '0, 4'b0111, 1, 0);
        for (int i = 0; i < 15; i++) begin
            step("R9", 4'b0000, 4'b1000, 0, '0, (i == 0) ? 4'b0111 : 4'b1111, 1, 0);
        end
        // R6 fence on input kind now drains at once
        step("R6", 4'b0000, 4'b0000, 1, order_word(4'b1000, 4'b0010), 4'b1111, 1, 0);
        step("R6", 4'b0000, 4'b0000, 0, '0, 4'b1101, 0, 0);
        step("R6", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);

        step("R1", 4'b0000, 4'b0000, 0, '0, 4'b1111, 1, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule